// File: doc/BRIEF.md
# Vector Instruction Exception Classifier

This block decides which architectural fault, if any, one decoded wide-vector instruction must raise. It receives the current operating mode, the prefix attributes found by the decoder, the vector-length and broadcast/rounding fields, a few control-register bits and a CPU feature flag. It also receives per-instruction fault-suppression and suppress-all-exceptions flags, precomputed memory-check status bits and a flag marking a pending unmasked floating-point exception. Address generation, segment checks, page walks and the arithmetic itself happen elsewhere; only their status bits arrive here.

Every applicable fault is collected into a vector, and a fixed priority picks the winner. Both are registered and presented one cycle after an input strobe, with a single-cycle valid. Memory faults are dropped when fault suppression is set. Only the full 512-bit vector length is legal. An alignment fault is never produced.

Top module: `vexc_classifier`

## Requirements
- R1: In real mode (mode=0) or virtual-8086 mode (mode=1), a present extended vector prefix (`vec_pfx`=1) raises invalid-opcode (fault_vec bit 0).
- R2: In protected/compatibility mode (mode=2) or 64-bit mode (mode=3), invalid-opcode is raised when `xsave_en` is 0, when `legacy_pfx` is 1, when `bcst_bit` is 1, or when `vl_field` is not 2'b10. None of these matter in modes 0 and 1.
- R3: In every mode, `lock_pfx`=1 or `feat_ok`=0 raises invalid-opcode.
- R4: In every mode, `task_sw`=1 raises device-not-available (fault_vec bit 1).
- R5: Stack (bit 2), general-protection (bit 3) and page faults (bit 4) are raised only when `fault_supp`=0. Stack comes from `ss_illegal` in mode 2 or `ss_noncanon` in mode 3. General-protection comes from `seg_illegal` in mode 2, `addr_noncanon` in mode 3, or `limit_ovf` in modes 0 and 1. Page fault comes from `page_flt` in modes 1, 2 and 3.
- R6: The SIMD floating-point exception (bit 5) is raised in every mode exactly when `fp_unmasked`=1, `sae`=0 and `xmm_exc_en`=1.
- R7: `fault_code` is 0 when no fault applies. Otherwise it is 1 + the index of the lowest set bit of `fault_vec`, giving the order invalid-opcode(1), device-not-available(2), stack(3), general-protection(4), page(5), SIMD floating-point(6). Code 7, and with it any alignment fault, is never produced.
- R8: `out_valid` is 1 for exactly the cycle after each cycle in which `in_valid` is 1. `fault_vec` and `fault_code` then show that request's result.
- R9: During reset `out_valid`, `fault_vec` and `fault_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled with it |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| vec_pfx | input | 1 | Extended vector prefix present |
| lock_pfx | input | 1 | LOCK prefix precedes the instruction |
| legacy_pfx | input | 1 | REX, F2, F3 or 66 prefix precedes the vector prefix |
| bcst_bit | input | 1 | Broadcast/rounding bit of the vector prefix |
| vl_field | input | 2 | Vector-length field |
| xsave_en | input | 1 | OS extended-state enable control bit |
| xmm_exc_en | input | 1 | OS SIMD floating-point exception support bit |
| task_sw | input | 1 | Task-switched control bit |
| feat_ok | input | 1 | Required CPU feature flag |
| fault_supp | input | 1 | Memory fault suppression for this instruction |
| sae | input | 1 | Suppress-all-exceptions flag |
| ss_illegal | input | 1 | Illegal stack-segment address |
| ss_noncanon | input | 1 | Non-canonical stack-segment address |
| seg_illegal | input | 1 | Illegal data-segment effective address |
| addr_noncanon | input | 1 | Non-canonical data address |
| limit_ovf | input | 1 | Operand outside 0..FFFFh |
| page_flt | input | 1 | Page fault reported by the walker |
| fp_unmasked | input | 1 | Unmasked floating-point exception pending |
| out_valid | output | 1 | Result valid, one cycle |
| fault_vec | output | 6 | All applicable faults, bit 0 invalid-opcode .. bit 5 SIMD FP |
| fault_code | output | 3 | Winning fault code, 0 = none |

## Verification
On every cycle, the assertions check several things. Each request produces exactly one valid pulse. A LOCK prefix, a set task-switched bit or an early-mode vector prefix always shows up in the vector. Fault suppression clears every memory fault, and suppress-all-exceptions clears the floating-point fault. The reported code always names the lowest set bit. The mode-dependent applicability of each memory check and each prefix rule, and the full priority order under many simultaneous faults, can only be shown by the bench. It does this by sweeping each single condition across all four modes and comparing random multi-fault requests with its own reference function.

// File: rtl/vexc_pkg.sv
// Shared types and constants for the vector exception classifier.
// Assumes fault indices double as priority order (lower index wins).
package vexc_pkg;
    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    localparam int NUM_FAULT = 6;
    localparam int CODE_W    = $clog2(NUM_FAULT + 1);

    localparam int FLT_UD = 0;
    localparam int FLT_NM = 1;
    localparam int FLT_SS = 2;
    localparam int FLT_GP = 3;
    localparam int FLT_PF = 4;
    localparam int FLT_XM = 5;

    localparam logic [1:0] VL_FULL = 2'b10;
endpackage

// File: rtl/vexc_insn_eval.sv
// Instruction-level checks: invalid-opcode, device-not-available and the
// SIMD floating-point exception. Purely combinational; assumes all inputs
// are stable while the request strobe is high.
module vexc_insn_eval
    import vexc_pkg::*;
#(
    parameter logic [1:0] VL_REQ = VL_FULL
) (
    input  cpu_mode_e  mode,
    input  logic       vec_pfx,
    input  logic       lock_pfx,
    input  logic       legacy_pfx,
    input  logic       bcst_bit,
    input  logic [1:0] vl_field,
    input  logic       xsave_en,
    input  logic       xmm_exc_en,
    input  logic       task_sw,
    input  logic       feat_ok,
    input  logic       sae,
    input  logic       fp_unmasked,
    output logic       ud_hit,
    output logic       nm_hit,
    output logic       xm_hit
);
    logic early_mode;

    // Classify the operating mode into early (real/v86) and late groups.
    always_comb early_mode = (mode == MODE_REAL) || (mode == MODE_V86);

    // Collect every invalid-opcode source for the current mode.
    always_comb begin
        ud_hit = lock_pfx || !feat_ok;
        if (early_mode) begin
            ud_hit = ud_hit || vec_pfx;
        end else begin
            ud_hit = ud_hit || !xsave_en || legacy_pfx || bcst_bit
                     || (vl_field != VL_REQ);
        end
    end

    // Device-not-available and floating-point checks apply in all modes.
    always_comb begin
        nm_hit = task_sw;
        xm_hit = fp_unmasked && !sae && xmm_exc_en;
    end
endmodule

// File: rtl/vexc_mem_eval.sv
// Memory-operand checks: stack, general-protection and page faults.
// Assumes the address and segment status bits are precomputed upstream;
// all three faults are dropped when fault suppression is set.
module vexc_mem_eval
    import vexc_pkg::*;
(
    input  cpu_mode_e mode,
    input  logic      fault_supp,
    input  logic      ss_illegal,
    input  logic      ss_noncanon,
    input  logic      seg_illegal,
    input  logic      addr_noncanon,
    input  logic      limit_ovf,
    input  logic      page_flt,
    output logic      ss_hit,
    output logic      gp_hit,
    output logic      pf_hit
);
    logic ss_raw, gp_raw, pf_raw;

    // Select which status bits count in the current mode.
    always_comb begin
        ss_raw = 1'b0;
        gp_raw = 1'b0;
        pf_raw = 1'b0;
        unique case (mode)
            MODE_REAL: gp_raw = limit_ovf;
            MODE_V86: begin
                gp_raw = limit_ovf;
                pf_raw = page_flt;
            end
            MODE_PROT: begin
                ss_raw = ss_illegal;
                gp_raw = seg_illegal;
                pf_raw = page_flt;
            end
            MODE_LONG: begin
                ss_raw = ss_noncanon;
                gp_raw = addr_noncanon;
                pf_raw = page_flt;
            end
            default: ;
        endcase
    end

    // Apply the per-instruction fault-suppression gate.
    always_comb begin
        ss_hit = ss_raw && !fault_supp;
        gp_hit = gp_raw && !fault_supp;
        pf_hit = pf_raw && !fault_supp;
    end
endmodule

// File: rtl/vexc_prio.sv
// Fixed-priority encoder: returns 1 + index of the lowest set request,
// or 0 when no request is set. Assumes N + 1 fits in the code width.
module vexc_prio #(
    parameter int N      = 6,
    localparam int CW    = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic [CW-1:0] code
);
    // Scan from the lowest-priority end so the lowest index ends up winning.
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = CW'(i + 1);
        end
    end
endmodule

// File: rtl/vexc_classifier.sv
// Top of the vector exception classifier. Combines the instruction-level
// and memory checks, picks the winning fault by fixed priority and
// registers the result for one cycle after each request strobe.
// Assumes a synchronous active-low reset.
module vexc_classifier
    import vexc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic                 vec_pfx,
    input  logic                 lock_pfx,
    input  logic                 legacy_pfx,
    input  logic                 bcst_bit,
    input  logic [1:0]           vl_field,
    input  logic                 xsave_en,
    input  logic                 xmm_exc_en,
    input  logic                 task_sw,
    input  logic                 feat_ok,
    input  logic                 fault_supp,
    input  logic                 sae,
    input  logic                 ss_illegal,
    input  logic                 ss_noncanon,
    input  logic                 seg_illegal,
    input  logic                 addr_noncanon,
    input  logic                 limit_ovf,
    input  logic                 page_flt,
    input  logic                 fp_unmasked,
    output logic                 out_valid,
    output logic [NUM_FAULT-1:0] fault_vec,
    output logic [CODE_W-1:0]    fault_code
);
    cpu_mode_e            mode_e;
    logic                 ud_hit, nm_hit, xm_hit, ss_hit, gp_hit, pf_hit;
    logic [NUM_FAULT-1:0] hit_vec;
    logic [CODE_W-1:0]    win_code;

    // Give the raw mode bits their enumerated meaning.
    always_comb mode_e = cpu_mode_e'(mode);

    vexc_insn_eval #(.VL_REQ(VL_FULL)) insn_i (
        .mode(mode_e), .vec_pfx(vec_pfx), .lock_pfx(lock_pfx),
        .legacy_pfx(legacy_pfx), .bcst_bit(bcst_bit), .vl_field(vl_field),
        .xsave_en(xsave_en), .xmm_exc_en(xmm_exc_en), .task_sw(task_sw),
        .feat_ok(feat_ok), .sae(sae), .fp_unmasked(fp_unmasked),
        .ud_hit(ud_hit), .nm_hit(nm_hit), .xm_hit(xm_hit)
    );

    vexc_mem_eval mem_i (
        .mode(mode_e), .fault_supp(fault_supp), .ss_illegal(ss_illegal),
        .ss_noncanon(ss_noncanon), .seg_illegal(seg_illegal),
        .addr_noncanon(addr_noncanon), .limit_ovf(limit_ovf),
        .page_flt(page_flt), .ss_hit(ss_hit), .gp_hit(gp_hit), .pf_hit(pf_hit)
    );

    // Place each fault at its priority index.
    always_comb begin
        hit_vec         = '0;
        hit_vec[FLT_UD] = ud_hit;
        hit_vec[FLT_NM] = nm_hit;
        hit_vec[FLT_SS] = ss_hit;
        hit_vec[FLT_GP] = gp_hit;
        hit_vec[FLT_PF] = pf_hit;
        hit_vec[FLT_XM] = xm_hit;
    end

    vexc_prio #(.N(NUM_FAULT)) prio_i (.req(hit_vec), .code(win_code));

    // Register the result and a one-cycle valid for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            fault_vec  <= '0;
            fault_code <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fault_vec  <= hit_vec;
                fault_code <= win_code;
            end
        end
    end
endmodule

// File: rtl/vexc_classifier_chk.sv
// Assertion checker for vexc_classifier, attached with bind below.
module vexc_classifier_chk
    import vexc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           mode,
    input logic                 vec_pfx,
    input logic                 lock_pfx,
    input logic                 xsave_en,
    input logic                 task_sw,
    input logic                 fault_supp,
    input logic                 sae,
    input logic                 out_valid,
    input logic [NUM_FAULT-1:0] fault_vec,
    input logic [CODE_W-1:0]    fault_code
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_early_vec_ud_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_pfx && !mode[1]) |=> fault_vec[FLT_UD]);
    assert_xsave_ud_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && !xsave_en) |=> fault_vec[FLT_UD]);
    assert_lock_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lock_pfx) |=> fault_vec[FLT_UD]);
    assert_ts_nm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && task_sw) |=> fault_vec[FLT_NM]);
    assert_supp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fault_supp) |=> (fault_vec[FLT_PF:FLT_SS] == '0));
    assert_sae_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sae) |=> !fault_vec[FLT_XM]);
    assert_code_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault_vec == '0) |-> (fault_code == '0));
    assert_code_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault_code != '0) |->
            (fault_code <= CODE_W'(NUM_FAULT)) && fault_vec[fault_code - 1'b1]
            && ((fault_vec & ((NUM_FAULT'(1) << (fault_code - 1'b1)) - 1'b1)) == '0));
endmodule

bind vexc_classifier vexc_classifier_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .vec_pfx(vec_pfx), .lock_pfx(lock_pfx), .xsave_en(xsave_en),
    .task_sw(task_sw), .fault_supp(fault_supp), .sae(sae),
    .out_valid(out_valid), .fault_vec(fault_vec), .fault_code(fault_code)
);

// File: tb/vexc_classifier_tb_top.sv
module vexc_classifier_tb_top;
    typedef struct packed {
        logic [1:0] mode;
        logic vec_pfx, lock_pfx, legacy_pfx, bcst_bit;
        logic [1:0] vl_field;
        logic xsave_en, xmm_exc_en, task_sw, feat_ok, fault_supp, sae;
        logic ss_illegal, ss_noncanon, seg_illegal, addr_noncanon;
        logic limit_ovf, page_flt, fp_unmasked;
    } stim_t;

    logic clk = 0, rst_n = 0, in_valid = 0;
    stim_t s;
    logic out_valid;
    logic [5:0] fault_vec;
    logic [2:0] fault_code;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vexc_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(s.mode),
        .vec_pfx(s.vec_pfx), .lock_pfx(s.lock_pfx), .legacy_pfx(s.legacy_pfx),
        .bcst_bit(s.bcst_bit), .vl_field(s.vl_field), .xsave_en(s.xsave_en),
        .xmm_exc_en(s.xmm_exc_en), .task_sw(s.task_sw), .feat_ok(s.feat_ok),
        .fault_supp(s.fault_supp), .sae(s.sae), .ss_illegal(s.ss_illegal),
        .ss_noncanon(s.ss_noncanon), .seg_illegal(s.seg_illegal),
        .addr_noncanon(s.addr_noncanon), .limit_ovf(s.limit_ovf),
        .page_flt(s.page_flt), .fp_unmasked(s.fp_unmasked),
        .out_valid(out_valid), .fault_vec(fault_vec), .fault_code(fault_code)
    );

    function automatic stim_t clean_stim(logic [1:0] m);
        stim_t c = '0;
        c.mode = m; c.vl_field = 2'b10; c.xsave_en = 1;
        c.xmm_exc_en = 1; c.feat_ok = 1;
        return c;
    endfunction

    // Reference fault vector from the requirements (R1..R6).
    function automatic logic [5:0] ref_vec(stim_t t);
        logic [5:0] v = '0;
        logic early = (t.mode < 2);
        v[0] = t.lock_pfx || !t.feat_ok || (early && t.vec_pfx) ||
               (!early && (!t.xsave_en || t.legacy_pfx || t.bcst_bit || t.vl_field != 2'b10));
        v[1] = t.task_sw;
        v[2] = !t.fault_supp && ((t.mode == 2 && t.ss_illegal) || (t.mode == 3 && t.ss_noncanon));
        v[3] = !t.fault_supp && ((t.mode == 2 && t.seg_illegal) || (t.mode == 3 && t.addr_noncanon)
                                 || (early && t.limit_ovf));
        v[4] = !t.fault_supp && t.page_flt && t.mode != 0;
        v[5] = t.fp_unmasked && !t.sae && t.xmm_exc_en;
        return v;
    endfunction

    // Reference priority (R7).
    function automatic logic [2:0] ref_code(logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic pick(int denom);
        return ($urandom % denom) == 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one request and check vector, code and the single valid pulse (R8).
    task automatic run(stim_t t, string tag);
        logic [5:0] ev = ref_vec(t);
        s = t; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({tag, " R8 valid"}, 32'(out_valid), 32'd1);
        check({tag, " vec"}, 32'(fault_vec), 32'(ev));
        check({tag, " R7 code"}, 32'(fault_code), 32'(ref_code(ev)));
        @(negedge clk);
        check({tag, " R8 pulse"}, 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        s = clean_stim(2'd2);
        in_valid = 1;
        repeat (3) @(negedge clk);
        check("R9 reset valid", 32'(out_valid), 32'd0);
        check("R9 reset vec", 32'(fault_vec), 32'd0);
        check("R9 reset code", 32'(fault_code), 32'd0);
        in_valid = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // Single-condition sweep over all modes.
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 19; c++) begin
                stim_t t = clean_stim(2'(m));
                string tag;
                case (c)
                    0:  begin tag = "none R7"; end
                    1:  begin t.vec_pfx = 1;       tag = "R1 vec_pfx"; end
                    2:  begin t.xsave_en = 0;      tag = "R2 xsave"; end
                    3:  begin t.legacy_pfx = 1;    tag = "R2 legacy"; end
                    4:  begin t.bcst_bit = 1;      tag = "R2 bcst"; end
                    5:  begin t.vl_field = 2'b01;  tag = "R2 vl01"; end
                    6:  begin t.vl_field = 2'b11;  tag = "R2 vl11"; end
                    7:  begin t.lock_pfx = 1;      tag = "R3 lock"; end
                    8:  begin t.feat_ok = 0;       tag = "R3 feat"; end
                    9:  begin t.task_sw = 1;       tag = "R4 ts"; end
                    10: begin t.ss_illegal = 1;    tag = "R5 ss"; end
                    11: begin t.ss_noncanon = 1;   tag = "R5 ssnc"; end
                    12: begin t.seg_illegal = 1;   tag = "R5 seg"; end
                    13: begin t.addr_noncanon = 1; tag = "R5 nc"; end
                    14: begin t.limit_ovf = 1;     tag = "R5 limit"; end
                    15: begin t.page_flt = 1;      tag = "R5 pf"; end
                    16: begin t.page_flt = 1; t.limit_ovf = 1; t.seg_illegal = 1;
                              t.fault_supp = 1;    tag = "R5 supp"; end
                    17: begin t.fp_unmasked = 1;   tag = "R6 fp"; end
                    default: begin t.fp_unmasked = 1; t.sae = 1; tag = "R6 sae"; end
                endcase
                run(t, tag);
            end
        end

        // Directed: all faults at once in protected mode -> code 1 (R7).
        begin
            stim_t t = clean_stim(2'd2);
            t.lock_pfx = 1; t.task_sw = 1; t.ss_illegal = 1; t.seg_illegal = 1;
            t.page_flt = 1; t.fp_unmasked = 1;
            run(t, "R7 all");
            t.lock_pfx = 0;
            run(t, "R7 no-ud");
            t.xmm_exc_en = 0; t.fp_unmasked = 1; t.task_sw = 0; t.ss_illegal = 0;
            run(t, "R6 xmm_exc_en");
        end

        // Random multi-fault combinations.
        for (int n = 0; n < 600; n++) begin
            stim_t t;
            t.mode = 2'($urandom % 4);
            t.vec_pfx = pick(6); t.lock_pfx = pick(10); t.legacy_pfx = pick(10);
            t.bcst_bit = pick(10); t.vl_field = pick(8) ? 2'($urandom) : 2'b10;
            t.xsave_en = !pick(10); t.xmm_exc_en = !pick(6); t.task_sw = pick(6);
            t.feat_ok = !pick(12); t.fault_supp = pick(3); t.sae = pick(4);
            t.ss_illegal = pick(4); t.ss_noncanon = pick(4); t.seg_illegal = pick(4);
            t.addr_noncanon = pick(4); t.limit_ovf = pick(4); t.page_flt = pick(4);
            t.fp_unmasked = pick(2);
            run(t, "R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule